// File: doc/BRIEF.md
# SPI Serial Clock and Mode Generator

This block makes the serial clock for a flash-facing SPI master from its reference clock. It also tells the data serializer when to shift and when to sample. A 3-bit rate code picks a power-of-two divide ratio, from 2 up to 256. Two mode bits pick the resting level of the clock and choose which of its two edges carries the sampling point, so all four SPI modes are covered.

A transfer begins with a one-cycle start pulse together with a bit count. The generator then produces two clock edges for every bit. Each edge comes with a one-cycle strobe: shift or sample, depending on the phase setting. When the last edge has been sent, the generator reports idle again. The configuration word is tracked only while the generator is idle. While a transfer runs, the settings captured when it was accepted stay frozen, so a rate or mode change can never cut a bit short.

Configuration word layout (the bit positions are decoded by the neighbouring register block):
- bit 0: master enable
- bit 1: clock polarity
- bit 2: clock phase
- bits 5..3: rate code

Top module: `spi_sclk_gen`

## Requirements
- R1: While reset is asserted and right after it, idle_o is 1, sclk_o is 0, and shift_o and sample_o are 0.
- R2: With rate code c in cfg_i[5:3], every high and every low phase of sclk_o lasts 2^c reference cycles, giving a divide ratio of 2<<c. The first edge appears 2^c cycles after the clock edge that accepts start_i.
- R3: While idle, sclk_o rests at the polarity bit cfg_i[1]. A change to that bit while idle shows on sclk_o one cycle later.
- R4: With phase bit cfg_i[2]=0, sample_o pulses in the same cycle as each leading edge (sclk_o leaving its resting level). shift_o pulses with each trailing edge except the last. An N-bit transfer therefore gives N samples and N-1 shifts.
- R5: With cfg_i[2]=1, shift_o pulses with each leading edge and sample_o with each trailing edge, N of each for N bits.
- R6: An N-bit transfer produces exactly 2N edges. idle_o returns to 1 in the cycle of the last edge, and sclk_o is then at the polarity level.
- R7: Changes to cfg_i while a transfer runs have no effect on that transfer's rate, polarity or phase.
- R8: A start_i pulse during a transfer is ignored; the running transfer keeps its edge count.
- R9: start_i is ignored when the master bit cfg_i[0] is 0 or when nbits_i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_i | input | 6 | Configuration word: master, polarity, phase, rate code |
| start_i | input | 1 | One-cycle request to begin a transfer |
| nbits_i | input | BITCNT_W | Bit count of the requested transfer |
| sclk_o | output | 1 | Serial clock |
| shift_o | output | 1 | Serializer shift strobe, coincident with a clock edge |
| sample_o | output | 1 | Serializer sample strobe, coincident with a clock edge |
| idle_o | output | 1 | High when no transfer is in progress |

## Verification
The hardest situations to reach are the ones where inputs change in the middle of a transfer. These are a new configuration word, or a second start pulse, arriving while edges are still being produced. The directed tasks reach them by watching the cycle count after a start is accepted and then, a few cycles in, driving a different rate code, an inverted polarity and phase, or a fresh start pulse. The bench then checks that every edge interval, strobe level and the total edge count still match the settings captured at the start. It also checks that the new polarity appears only once the generator is idle.

// File: rtl/sclk_gen_pkg.sv
package sclk_gen_pkg;
  localparam int CODE_W   = 3;
  localparam int CFG_W    = 6;
  localparam int MSTR_BIT = 0;
  localparam int CPOL_BIT = 1;
  localparam int CPHA_BIT = 2;
  localparam int CODE_LSB = 3;
  localparam int HALF_MAX = 1 << ((1 << CODE_W) - 1);
  localparam int HCNT_W   = $clog2(HALF_MAX);

  typedef struct packed {
    logic              cpha;
    logic              cpol;
    logic [CODE_W-1:0] code;
  } mode_t;

  function automatic mode_t decode_cfg(input logic [CFG_W-1:0] w);
    mode_t m;
    m.cpha = w[CPHA_BIT];
    m.cpol = w[CPOL_BIT];
    m.code = w[CODE_LSB +: CODE_W];
    return m;
  endfunction
endpackage

// File: rtl/sclk_cfg_hold.sv
module sclk_cfg_hold
  import sclk_gen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             busy_i,
  output mode_t            mode_q
);
  mode_t mode_d;

  // Track the live word only while idle; freeze it during a transfer.
  always_comb begin
    mode_d = mode_q;
    if (!busy_i) mode_d = decode_cfg(cfg_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode_d;
  end

  assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy_i) |-> $stable(mode_q));
endmodule

// File: rtl/sclk_half_timer.sv
module sclk_half_timer
  import sclk_gen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              tick_o
);
  logic [HCNT_W-1:0] cnt_q, cnt_d, half_m1;

  // Each half phase lasts 2^code cycles, so the terminal count is 2^code - 1.
  always_comb begin
    half_m1 = HCNT_W'((32'd1 << code_i) - 32'd1);
    tick_o  = run_i && (cnt_q == half_m1);
    if (!run_i || tick_o) cnt_d = '0;
    else                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && code_i != '0 && $stable(code_i)) |=> !tick_o);
endmodule

// File: rtl/sclk_edge_seq.sv
module sclk_edge_seq #(
  parameter int BITCNT_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic                tick_i,
  input  logic                idle_pol_i,
  input  logic                cpha_i,
  input  logic [BITCNT_W-1:0] nbits_i,
  output logic                busy_o,
  output logic                sclk_o,
  output logic                shift_o,
  output logic                sample_o
);
  localparam int ECNT_W = BITCNT_W + 1;

  logic                busy_q, busy_d;
  logic [ECNT_W-1:0]   ecnt_q, ecnt_d, last_idx;
  logic [BITCNT_W-1:0] nbits_q, nbits_d;
  logic                sclk_q, sclk_d, shift_q, shift_d, samp_q, samp_d;
  logic                accept, leading, last_edge;

  always_comb begin
    accept    = load_i && !busy_q;
    last_idx  = {nbits_q, 1'b0} - ECNT_W'(1);
    leading   = !ecnt_q[0];
    last_edge = (ecnt_q == last_idx);

    busy_d  = busy_q;
    ecnt_d  = ecnt_q;
    nbits_d = nbits_q;
    sclk_d  = sclk_q;
    shift_d = 1'b0;
    samp_d  = 1'b0;

    if (!busy_q) begin
      sclk_d = idle_pol_i;
      if (accept) begin
        busy_d  = 1'b1;
        ecnt_d  = '0;
        nbits_d = nbits_i;
      end
    end else if (tick_i) begin
      sclk_d  = !sclk_q;
      ecnt_d  = ecnt_q + 1'b1;
      samp_d  = cpha_i ? !leading : leading;
      shift_d = cpha_i ? leading : (!leading && !last_edge);
      if (last_edge) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      ecnt_q  <= '0;
      nbits_q <= '0;
      sclk_q  <= 1'b0;
      shift_q <= 1'b0;
      samp_q  <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      ecnt_q  <= ecnt_d;
      nbits_q <= nbits_d;
      sclk_q  <= sclk_d;
      shift_q <= shift_d;
      samp_q  <= samp_d;
    end
  end

  assign busy_o   = busy_q;
  assign sclk_o   = sclk_q;
  assign shift_o  = shift_q;
  assign sample_o = samp_q;

  assert_sample_on_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |-> (sclk_o != $past(sclk_o)));
  assert_end_on_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> (sclk_o != $past(sclk_o)));
  assert_count_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy_q) && busy_q) |-> $stable(nbits_q));
endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen
  import sclk_gen_pkg::*;
#(
  parameter int BITCNT_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [5:0]          cfg_i,
  input  logic                start_i,
  input  logic [BITCNT_W-1:0] nbits_i,
  output logic                sclk_o,
  output logic                shift_o,
  output logic                sample_o,
  output logic                idle_o
);
  mode_t mode_q;
  logic  busy, tick, start_ok, live_pol;

  // Only a master-mode request with a non-zero bit count is accepted.
  always_comb begin
    start_ok = start_i && cfg_i[MSTR_BIT] && (nbits_i != '0);
    live_pol = cfg_i[CPOL_BIT];
  end

  sclk_cfg_hold u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .cfg_i  (cfg_i),
    .busy_i (busy),
    .mode_q (mode_q)
  );

  sclk_half_timer u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (busy),
    .code_i (mode_q.code),
    .tick_o (tick)
  );

  sclk_edge_seq #(.BITCNT_W(BITCNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (start_ok),
    .tick_i     (tick),
    .idle_pol_i (live_pol),
    .cpha_i     (mode_q.cpha),
    .nbits_i    (nbits_i),
    .busy_o     (busy),
    .sclk_o     (sclk_o),
    .shift_o    (shift_o),
    .sample_o   (sample_o)
  );

  assign idle_o = !busy;

  assert_idle_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> (sclk_o == mode_q.cpol));
  assert_sample_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |-> (sclk_o == (mode_q.cpha ? mode_q.cpol : !mode_q.cpol)));
  assert_shift_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    shift_o |-> (sclk_o == (mode_q.cpha ? !mode_q.cpol : mode_q.cpol)));
endmodule

// File: tb/tb_spi_sclk_gen.sv
module tb_spi_sclk_gen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] cfg;
  logic       start;
  logic [5:0] nbits;
  logic       sclk, shift, sample, idle;
  int         checks = 0;
  int         fails  = 0;

  always #5 clk = ~clk;

  spi_sclk_gen dut (
    .clk(clk), .rst_n(rst_n), .cfg_i(cfg), .start_i(start), .nbits_i(nbits),
    .sclk_o(sclk), .shift_o(shift), .sample_o(sample), .idle_o(idle)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic logic [5:0] mk(input int code, input int cpol, input int cpha, input int m);
    return {3'(code), 1'(cpha), 1'(cpol), 1'(m)};
  endfunction

  // disturb: 0 none, 1 new config mid-transfer, 2 extra start pulse mid-transfer
  task automatic run_xfer(input int code, input int cpol, input int cpha, input int n, input int disturb);
    int h, cyc, last_t, tog, bad_int, bad_lvl, nsamp, nshift, first_t;
    logic prev;
    h = 1 << code;
    @(negedge clk);
    cfg = mk(code, cpol, cpha, 1); nbits = 6'(n);
    @(negedge clk);
    chk(sclk == 1'(cpol) && idle, "R3 idle level before start", int'(sclk), cpol);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0; last_t = 0; tog = 0; bad_int = 0; bad_lvl = 0; nsamp = 0; nshift = 0; first_t = -1;
    prev = sclk;
    chk(!idle, "R6 busy after accepted start", int'(idle), 0);
    while (!idle && cyc < 2 * n * h + 20) begin
      @(negedge clk);
      cyc++;
      if (sclk != prev) begin
        tog++;
        if (first_t < 0) first_t = cyc;
        if (cyc - last_t != h) bad_int++;
        last_t = cyc;
      end
      if (sample) begin
        nsamp++;
        if (sclk != (cpha != 0 ? 1'(cpol) : !1'(cpol)) || sclk == prev) bad_lvl++;
      end
      if (shift) begin
        nshift++;
        if (sclk != (cpha != 0 ? !1'(cpol) : 1'(cpol)) || sclk == prev) bad_lvl++;
      end
      prev = sclk;
      if (cyc == 3 && disturb == 1) cfg = mk(code == 0 ? 1 : 0, 1 - cpol, 1 - cpha, 1);
      if (cyc == 3 && disturb == 2) start = 1'b1;
      if (cyc == 4) start = 1'b0;
    end
    chk(first_t == h, "R2 first edge delay", first_t, h);
    chk(bad_int == 0, "R2 half-phase length", bad_int, 0);
    chk(tog == 2 * n, "R6 R8 edge count", tog, 2 * n);
    chk(cyc == 2 * n * h, "R6 idle at last edge", cyc, 2 * n * h);
    chk(sclk == 1'(cpol), "R6 final level", int'(sclk), cpol);
    chk(bad_lvl == 0, cpha != 0 ? "R5 strobe alignment" : "R4 strobe alignment", bad_lvl, 0);
    chk(nsamp == n, cpha != 0 ? "R5 sample count" : "R4 sample count", nsamp, n);
    chk(nshift == (cpha != 0 ? n : n - 1), cpha != 0 ? "R5 shift count" : "R4 shift count",
        nshift, cpha != 0 ? n : n - 1);
    if (disturb == 1) begin
      chk(bad_int == 0 && bad_lvl == 0, "R7 mid-transfer config ignored", bad_int + bad_lvl, 0);
      @(negedge clk);
      chk(sclk == !1'(cpol), "R3 new polarity applies once idle", int'(sclk), 1 - cpol);
    end
  endtask

  task automatic no_start(input logic [5:0] c, input int n, input string req);
    int moved;
    @(negedge clk);
    cfg = c; nbits = 6'(n);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    moved = 0;
    for (int i = 0; i < 10; i++) begin
      if (!idle || sclk != c[1] || shift || sample) moved++;
      @(negedge clk);
    end
    chk(moved == 0, req, moved, 0);
  endtask

  task automatic reset_test();
    rst_n = 1'b0; start = 1'b0; cfg = 6'b000001; nbits = 6'd1;
    repeat (3) @(negedge clk);
    chk(idle && !sclk && !shift && !sample, "R1 outputs in reset",
        {idle, sclk, shift, sample}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(idle && !sclk && !shift && !sample, "R1 outputs after reset",
        {idle, sclk, shift, sample}, 4'b1000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R6 watchdog expired act=1 exp=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    reset_test();
    run_xfer(0, 0, 0, 8, 0);
    run_xfer(0, 1, 0, 5, 0);
    run_xfer(1, 0, 1, 4, 0);
    run_xfer(2, 1, 1, 3, 0);
    run_xfer(7, 0, 0, 2, 0);
    run_xfer(3, 0, 1, 1, 0);
    run_xfer(0, 0, 0, 1, 0);
    run_xfer(1, 0, 0, 4, 1);
    run_xfer(1, 1, 0, 3, 2);
    no_start(mk(1, 0, 0, 0), 4, "R9 start ignored without master bit");
    no_start(mk(1, 1, 0, 1), 0, "R9 start ignored with zero bit count");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule